// File: doc/BRIEF.md
# Glitch-Free Clock Bank Gate

This block decides what one bank of clock outputs does. It uses a bank disable line and a two-bit code for the output mode, which represents a three-level strap. The bank can be in one of four states. It can drive its source clock. It can be parked LOW in a power-saving hold-off state. It can be released to high impedance. In test mode it passes the reference clock straight through in place of the synthesized clock. Every stop and restart of the gated clock takes effect only while the source is LOW, so no shortened pulse ever reaches the pins.

Both clocks enter as levels that the fast block clock `clk` samples. The source clock's high and low phases must each last at least two `clk` cycles. The disable line is re-timed by a two-stage synchronizer that advances once per source period, on each source falling edge. This puts an upper bound of six source periods on the hold-off latency.

In test mode a second line, the test-reset request, sends the bank to high impedance at once. It then waits for five rising reference edges and asserts a reset to the neighbouring state machines. That reset holds until the request drops. This block's own gate and synchronizer are forced to their reset state along with them.

Top module: `clk_bank_gate`

## Requirements
- R1: With `disIn` LOW and a non-test mode, `bankOe` is 1 and `bankClk` repeats the source clock, one rising edge per source period.
- R2: With mode code 2'b10 (high-impedance mode) and `disIn` HIGH, `bankOe` is 0 in the same cycle, with no clock edge needed.
- R3: With mode code 2'b00 (hold-off mode), raising `disIn` parks `bankClk` LOW within six source periods and keeps it LOW, while `bankOe` stays 1. Dropping `disIn` restarts the clock within six source periods.
- R4: The gate opens and closes only while the source is LOW. Every high pulse on `bankClk` lasts exactly as long as the source high phase, whenever it stops or restarts.
- R5: Mode codes 2'b01 and 2'b11 select test mode. There `bankClk` repeats the reference clock, `bankOe` is 1, and `disIn` has no effect.
- R6: In test mode, raising `tstRstIn` drops `bankOe` in the same cycle. `fsmRstOut` rises only after the fifth rising reference edge that follows the request.
- R7: `fsmRstOut` stays HIGH and `bankOe` stays 0 while the test-reset request is held. Dropping the request clears both conditions at once, and the reference clock resumes on `bankClk`.
- R8: During reset `bankClk` and `fsmRstOut` are 0. After reset the gate opens at the first source falling edge, so the first high pulse has full width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that samples both clock levels |
| rstN | input | 1 | Asynchronous active-low reset |
| srcClk | input | 1 | Synthesized source clock level |
| refClk | input | 1 | Reference clock level, used for bypass and edge counting |
| modeIn | input | 2 | Output mode code: 00 hold-off, 10 high-impedance, 01/11 test |
| disIn | input | 1 | Bank disable request |
| tstRstIn | input | 1 | Test-reset request, active in test mode only |
| bankClk | output | 1 | Gated bank clock |
| bankOe | output | 1 | Drive enable for the bank pads |
| fsmRstOut | output | 1 | Deterministic-state reset for neighbouring state machines |

## Verification
The bench uses a source period of six `clk` cycles and a reference period of ten. From the count of rising edges in a 60-cycle window it can tell three cases apart: the bank following the source (10 edges), following the reference (6 edges), or parked (0 edges). A table of mode and disable combinations is run through that count and through the drive enable. Hold-off stop and restart are repeated at six different phase offsets against the source, while a monitor records every high-pulse width. The test-reset run checks the reset output one cycle window after the fourth reference edge and again after the fifth. It then checks that the state holds and that the bank recovers once the request drops.

// File: rtl/clk_bank_gate_pkg.sv
package clk_bank_gate_pkg;

  typedef enum logic [1:0] {
    OM_HOLD = 2'b00,
    OM_TEST = 2'b01,
    OM_HIZ  = 2'b10,
    OM_OPEN = 2'b11
  } outModeE;

  typedef enum logic {
    GATE_PARK = 1'b0,
    GATE_RUN  = 1'b1
  } gateStateE;

  // strobes from control to datapath
  typedef struct packed {
    logic gateOpen;
    logic useRef;
    logic drvOn;
  } bankCmdS;

  function automatic logic isTestMode(input logic [1:0] m);
    return (m == OM_TEST) || (m == OM_OPEN);
  endfunction

endpackage

// File: rtl/clk_bank_gate_dp.sv
module clk_bank_gate_dp
  import clk_bank_gate_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    srcClk,
  input  logic    refClk,
  input  bankCmdS cmd,
  output logic    srcFall,
  output logic    refRise,
  output logic    bankClk,
  output logic    bankOe
);

  logic srcQ, srcQ2, refQ, refQ2, outQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcQ  <= 1'b0;
      srcQ2 <= 1'b0;
      refQ  <= 1'b0;
      refQ2 <= 1'b0;
    end else begin
      srcQ  <= srcClk;
      srcQ2 <= srcQ;
      refQ  <= refClk;
      refQ2 <= refQ;
    end
  end

  assign srcFall = srcQ2 & ~srcQ;
  assign refRise = refQ & ~refQ2;

  // output stage: reference bypass in test, otherwise gated source
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outQ <= 1'b0;
    else       outQ <= cmd.useRef ? refQ : (srcQ & cmd.gateOpen);
  end

  assign bankClk = outQ;
  assign bankOe  = cmd.drvOn;

endmodule

// File: rtl/clk_bank_gate_ctrl.sv
module clk_bank_gate_ctrl
  import clk_bank_gate_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int REF_EDGES   = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeIn,
  input  logic       disIn,
  input  logic       tstRstIn,
  input  logic       srcFall,
  input  logic       refRise,
  output bankCmdS    cmd,
  output logic       fsmRstOut
);

  localparam int CNT_W = $clog2(REF_EDGES + 1);
  localparam int LAST  = SYNC_STAGES - 1;

  logic             testMode, rstReq, hizReq;
  logic [CNT_W-1:0] edgeCnt;
  logic [LAST:0]    syncQ;
  gateStateE        gateSt;

  assign testMode = isTestMode(modeIn);
  assign rstReq   = testMode & tstRstIn;
  assign hizReq   = ((modeIn == OM_HIZ) & disIn) | rstReq;

  // reference edge counter for the test reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                        edgeCnt <= '0;
    else if (!rstReq)                                 edgeCnt <= '0;
    else if (refRise && edgeCnt != CNT_W'(REF_EDGES)) edgeCnt <= edgeCnt + 1'b1;
  end

  assign fsmRstOut = rstReq && (edgeCnt == CNT_W'(REF_EDGES));

  // disable synchronizer, one step per source falling edge
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          syncQ[s] <= 1'b0;
      else if (fsmRstOut) syncQ[s] <= 1'b0;
      else if (srcFall)   syncQ[s] <= (s == 0) ? disIn : syncQ[(s == 0) ? 0 : s - 1];
    end
  end

  // gate moves only in the low phase of the source
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          gateSt <= GATE_PARK;
    else if (fsmRstOut) gateSt <= GATE_PARK;
    else if (srcFall)   gateSt <= syncQ[LAST] ? GATE_PARK : GATE_RUN;
  end

  always_comb begin
    cmd.gateOpen = (gateSt == GATE_RUN);
    cmd.useRef   = testMode;
    cmd.drvOn    = ~hizReq;
  end

endmodule

// File: rtl/clk_bank_gate.sv
module clk_bank_gate
  import clk_bank_gate_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int REF_EDGES   = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       srcClk,
  input  logic       refClk,
  input  logic [1:0] modeIn,
  input  logic       disIn,
  input  logic       tstRstIn,
  output logic       bankClk,
  output logic       bankOe,
  output logic       fsmRstOut
);

  bankCmdS cmd;
  logic    srcFall, refRise;

  clk_bank_gate_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .REF_EDGES  (REF_EDGES)
  ) ctrlI (
    .clk      (clk),
    .rstN     (rstN),
    .modeIn   (modeIn),
    .disIn    (disIn),
    .tstRstIn (tstRstIn),
    .srcFall  (srcFall),
    .refRise  (refRise),
    .cmd      (cmd),
    .fsmRstOut(fsmRstOut)
  );

  clk_bank_gate_dp dpI (
    .clk    (clk),
    .rstN   (rstN),
    .srcClk (srcClk),
    .refClk (refClk),
    .cmd    (cmd),
    .srcFall(srcFall),
    .refRise(refRise),
    .bankClk(bankClk),
    .bankOe (bankOe)
  );

endmodule

// File: rtl/clk_bank_gate_chk.sv
module clk_bank_gate_chk
  import clk_bank_gate_pkg::*;
#(
  parameter int REF_EDGES  = 5,
  parameter int HOLD_LIMIT = 6
) (
  input logic       clk,
  input logic       rstN,
  input logic       srcClk,
  input logic       refClk,
  input logic [1:0] modeIn,
  input logic       disIn,
  input logic       tstRstIn,
  input logic       bankClk,
  input logic       bankOe,
  input logic       fsmRstOut
);

  localparam int HW = $clog2(HOLD_LIMIT + 2);
  localparam int RW = $clog2(REF_EDGES + 2);

  logic          srcPrev, refPrev;
  logic [1:0]    modePrev;
  logic [1:0]    quietCnt;
  logic [HW-1:0] holdCnt;
  logic [RW-1:0] refCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcPrev  <= 1'b0;
      refPrev  <= 1'b0;
      modePrev <= 2'b00;
      quietCnt <= '0;
      holdCnt  <= '0;
      refCnt   <= '0;
    end else begin
      srcPrev  <= srcClk;
      refPrev  <= refClk;
      modePrev <= modeIn;
      if (modeIn != modePrev)  quietCnt <= '0;
      else if (quietCnt != 2'd3) quietCnt <= quietCnt + 1'b1;
      if (!(modeIn == OM_HOLD && disIn)) holdCnt <= '0;
      else if (srcPrev && !srcClk && holdCnt != HW'(HOLD_LIMIT + 1)) holdCnt <= holdCnt + 1'b1;
      if (!(isTestMode(modeIn) && tstRstIn)) refCnt <= '0;
      else if (!refPrev && refClk && refCnt != RW'(REF_EDGES + 1)) refCnt <= refCnt + 1'b1;
    end
  end

  // R1
  a_r1_enabled_drive: assert property (@(posedge clk) disable iff (!rstN)
    (!disIn && !isTestMode(modeIn)) |-> bankOe);

  // R2
  a_r2_hiz_now: assert property (@(posedge clk) disable iff (!rstN)
    (modeIn == OM_HIZ && disIn) |-> !bankOe);

  // R3
  a_r3_holdoff_bound: assert property (@(posedge clk) disable iff (!rstN)
    (holdCnt >= HW'(HOLD_LIMIT)) |-> !bankClk);

  // R4
  a_r4_no_runt: assert property (@(posedge clk) disable iff (!rstN)
    (quietCnt == 2'd3 && !isTestMode(modeIn) && $rose(bankClk)) |=> bankClk);

  // R5
  a_r5_test_drives: assert property (@(posedge clk) disable iff (!rstN)
    (isTestMode(modeIn) && !tstRstIn) |-> bankOe);

  // R6
  a_r6_rst_after_edges: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fsmRstOut) |-> (refCnt >= RW'(REF_EDGES)));

  a_r6_hiz_in_rst: assert property (@(posedge clk) disable iff (!rstN)
    (isTestMode(modeIn) && tstRstIn) |-> !bankOe);

  // R7
  a_r7_rst_hold: assert property (@(posedge clk) disable iff (!rstN)
    (fsmRstOut && isTestMode(modeIn) && tstRstIn) |=>
      (fsmRstOut || !tstRstIn || !isTestMode(modeIn)));

endmodule

bind clk_bank_gate clk_bank_gate_chk #(.REF_EDGES(REF_EDGES)) chkI (
  .clk      (clk),
  .rstN     (rstN),
  .srcClk   (srcClk),
  .refClk   (refClk),
  .modeIn   (modeIn),
  .disIn    (disIn),
  .tstRstIn (tstRstIn),
  .bankClk  (bankClk),
  .bankOe   (bankOe),
  .fsmRstOut(fsmRstOut)
);

// File: tb/clk_bank_gate_tb_top.sv
module clk_bank_gate_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       srcClk = 1'b0;
  logic       refClk = 1'b0;
  logic [1:0] modeIn = 2'b00;
  logic       disIn = 1'b0;
  logic       tstRstIn = 1'b0;
  logic       bankClk, bankOe, fsmRstOut;

  int total = 0;
  int fails = 0;
  int hiRun = 0;
  int runtErr = 0;
  bit monOn = 1'b0;
  int srcPh = 0;
  int refPh = 0;

  always #4 clk = ~clk;

  // free-running source (period 6) and reference (period 10)
  always @(negedge clk) begin
    srcPh  = (srcPh == 5) ? 0 : srcPh + 1;
    refPh  = (refPh == 9) ? 0 : refPh + 1;
    srcClk <= (srcPh < 3);
    refClk <= (refPh < 5);
  end

  clk_bank_gate dut_i (
    .clk(clk), .rstN(rstN), .srcClk(srcClk), .refClk(refClk),
    .modeIn(modeIn), .disIn(disIn), .tstRstIn(tstRstIn),
    .bankClk(bankClk), .bankOe(bankOe), .fsmRstOut(fsmRstOut)
  );

  // pulse-width monitor (R4): every high run must be 3 samples
  always @(posedge clk) begin
    #2;
    if (bankClk) hiRun++;
    else begin
      if (monOn && hiRun != 0 && hiRun != 3) runtErr++;
      hiRun = 0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #2;
    end
  endtask

  task automatic drive(input logic [1:0] m, input logic d, input logic t);
    @(negedge clk);
    modeIn   = m;
    disIn    = d;
    tstRstIn = t;
  endtask

  task automatic countRises(input int win, output int n);
    logic p;
    n = 0;
    p = bankClk;
    for (int k = 0; k < win; k++) begin
      @(posedge clk); #2;
      if (bankClk && !p) n++;
      p = bankClk;
    end
  endtask

  task automatic waitRefRise();
    logic p;
    p = refClk;
    for (int k = 0; k < 40; k++) begin
      @(posedge clk); #2;
      if (refClk && !p) return;
      p = refClk;
    end
  endtask

  // {mode[1:0], dis, tst, expOe, expRises[7:0]}; 8'hFF = no rise check
  localparam logic [12:0] VEC [7] = '{
    {2'b00, 1'b0, 1'b0, 1'b1, 8'd10},
    {2'b00, 1'b1, 1'b0, 1'b1, 8'd0},
    {2'b10, 1'b0, 1'b0, 1'b1, 8'd10},
    {2'b10, 1'b1, 1'b0, 1'b0, 8'hFF},
    {2'b01, 1'b0, 1'b0, 1'b1, 8'd6},
    {2'b01, 1'b1, 1'b0, 1'b1, 8'd6},
    {2'b11, 1'b1, 1'b0, 1'b1, 8'd6}
  };

  function automatic string tagOf(input int i);
    case (i)
      0, 2:    return "R1";
      1:       return "R3";
      3:       return "R2";
      default: return "R5";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int n;
    int run;
    // R8: reset state
    tick(5);
    chk("R8 bankClk in reset", int'(bankClk), 0);
    chk("R8 fsmRstOut in reset", int'(fsmRstOut), 0);
    @(negedge clk); rstN = 1'b1;
    tick(1);
    chk("R8 bankClk right after reset", int'(bankClk), 0);
    for (int k = 0; k < 50 && !bankClk; k++) tick(1);
    run = 0;
    for (int k = 0; k < 20 && bankClk; k++) begin run++; tick(1); end
    chk("R8 first pulse width", run, 3);

    // table walk
    for (int i = 0; i < 7; i++) begin
      drive(VEC[i][12:11], VEC[i][10], VEC[i][9]);
      tick(40);
      chk({tagOf(i), " oe"}, int'(bankOe), int'(VEC[i][8]));
      if (VEC[i][7:0] != 8'hFF) begin
        countRises(60, n);
        chk({tagOf(i), " rises"}, n, int'(VEC[i][7:0]));
      end
    end

    // R2: high-impedance without waiting for an edge
    drive(2'b10, 1'b0, 1'b0);
    tick(40);
    @(negedge clk); disIn = 1'b1;
    #1;
    chk("R2 oe same cycle", int'(bankOe), 0);

    // R3/R4: hold-off stop and restart at six phases
    drive(2'b00, 1'b0, 1'b0);
    tick(40);
    runtErr = 0;
    monOn = 1'b1;
    for (int ph = 0; ph < 6; ph++) begin
      tick(ph);
      drive(2'b00, 1'b1, 1'b0);
      tick(36);
      countRises(60, n);
      chk("R3 parked rises", n, 0);
      chk("R3 parked level", int'(bankClk), 0);
      chk("R3 oe in hold-off", int'(bankOe), 1);
      drive(2'b00, 1'b0, 1'b0);
      tick(36);
      countRises(60, n);
      chk("R3 restart rises", n, 10);
    end
    tick(4);
    monOn = 1'b0;
    chk("R4 runt pulses", runtErr, 0);

    // R6/R7: test reset sequencing
    drive(2'b01, 1'b0, 1'b0);
    tick(20);
    for (int k = 0; k < 20 && refClk; k++) tick(1);
    @(negedge clk); tstRstIn = 1'b1;
    #1;
    chk("R6 oe drops at once", int'(bankOe), 0);
    for (int e = 0; e < 4; e++) waitRefRise();
    tick(3);
    chk("R6 no reset after four edges", int'(fsmRstOut), 0);
    waitRefRise();
    tick(3);
    chk("R6 reset after fifth edge", int'(fsmRstOut), 1);
    tick(40);
    chk("R7 reset held", int'(fsmRstOut), 1);
    chk("R7 oe held off", int'(bankOe), 0);
    @(negedge clk); tstRstIn = 1'b0;
    #1;
    chk("R7 reset released", int'(fsmRstOut), 0);
    chk("R7 oe restored", int'(bankOe), 1);
    tick(10);
    countRises(60, n);
    chk("R7 reference resumes", n, 6);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule